// File: doc/BRIEF.md
# Edge Delay Compensation Scheduler

This block sits at the last gateway of a deterministic path that crosses several timing domains. Each packet descriptor arrives with three things: a flow number and path number, the residence time already summed over the earlier domains, and the time at which the packet entered the final domain. The block takes its own free-running time counter at the moment it accepts the descriptor. The difference between that counter value and the entry time is the residence in the final domain. The block adds this to the carried sum to get the total residence.

For each flow and path pair, a configuration port holds a capacity. The capacity is the common path budget minus the fixed propagation share. The block holds each descriptor for the capacity minus the total residence, and then presents it on a valid/ready output. Every copy of a flow therefore leaves with the same end-to-end latency, whichever path it took.

Held descriptors wait in a small queue that releases in arrival order. When the queue is full, the input stalls.

Top module: `edc_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `over_budget` are 0, `in_ready` is 1, and `now` equals the parameter `TIME_INIT`.
- R2: `now` increases by exactly one per clock and wraps from all-ones to zero.
- R3: For a descriptor accepted at a clock edge where `now` = A, let total = `in_acc_res` + (A − `in_ingress_ts`) and comp = cap − total. The descriptor first shows on `out_valid` in the cycle where `now` = max(A + comp, A + 1), provided no earlier descriptor holds the output. Every accepted descriptor is emitted exactly once.
- R4: Capacities are stored per (flow, path) pair at index flow·2^PATH_W + path. A write through `cfg_we`/`cfg_flow`/`cfg_path`/`cfg_cap` changes only that pair's capacity.
- R5: If the total exceeds the capacity, comp is 0 and `over_budget` goes to 1 one edge later and stays 1 until reset. A total equal to the capacity gives comp 0 and does not set the flag.
- R6: Descriptors leave in the order they were accepted. A descriptor whose own release time is earlier than that of the most recently queued entry is given that entry's release time instead. At most one descriptor leaves per cycle.
- R7: `in_ready` is 0 while DEPTH descriptors are held. An `in_valid` during that time has no effect, and no extra descriptor ever reaches the output.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_flow`, `out_path` and `out_tag` stay unchanged.
- R9: A capacity write applies to descriptors accepted at later edges. A descriptor accepted at the same edge as the write uses the old capacity.
- R10: Release-time comparisons use signed differences modulo 2^32, so a release time beyond the counter wrap is honoured at the right cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Capacity write strobe |
| cfg_flow | input | FLOW_W | Flow number for the write |
| cfg_path | input | PATH_W | Path number for the write |
| cfg_cap | input | 32 | Capacity value in time units |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Queue has room |
| in_flow | input | FLOW_W | Descriptor flow number |
| in_path | input | PATH_W | Descriptor path number |
| in_acc_res | input | 32 | Residence summed over the earlier domains |
| in_ingress_ts | input | 32 | Entry time into the final domain |
| in_tag | input | TAG_W | Opaque descriptor handle |
| out_valid | output | 1 | Head descriptor is due |
| out_ready | input | 1 | Downstream takes the head |
| out_flow | output | FLOW_W | Released flow number |
| out_path | output | PATH_W | Released path number |
| out_tag | output | TAG_W | Released handle |
| over_budget | output | 1 | Sticky: some total exceeded its capacity |
| now | output | 32 | Local free-running time counter |

## Verification
A descriptor accepted at the edge where `now` reads A is first visible at the falling edge of the cycle where `now` is max(release, A+1). The reference model also adds a one-cycle step for each descriptor still ahead of it in the queue. The monitor samples at falling edges and compares the `now` value it sees against that predicted number, so early and late releases both show up as mismatches.

The sticky flag is registered at the accepting edge and is read only after the descriptor drains. The counter step is read one falling edge apart. The stall, full-queue and same-edge-write cases are stepped one edge at a time, with each output read at the first falling edge at which it can change.

// File: rtl/edc_pkg.sv
package edc_pkg;
    localparam int unsigned TS_W = 32;
    typedef logic [TS_W-1:0] ts_t;

    // now has reached or passed due, modulo 2^TS_W
    function automatic logic ts_reached(ts_t now_v, ts_t due_v);
        ts_t diff;
        diff = now_v - due_v;
        return ~diff[TS_W-1];
    endfunction

    // a lies strictly after b, modulo 2^TS_W
    function automatic logic ts_after(ts_t a, ts_t b);
        ts_t diff;
        diff = a - b;
        return ~diff[TS_W-1] && (diff != '0);
    endfunction
endpackage

// File: rtl/edc_cap_table.sv
module edc_cap_table
    import edc_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  ts_t               wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output ts_t               rd_data
);
    localparam int unsigned NENT = 1 << ADDR_W;

    typedef struct packed {
        logic [NENT-1:0][TS_W-1:0] cap;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.cap[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // old value is read for a lookup in the same cycle as a write
    assign rd_data = st_q.cap[rd_addr];

    p_cfg_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.cap[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/edc_budget.sv
module edc_budget
    import edc_pkg::*;
(
    input  ts_t  now_i,
    input  ts_t  ingress_i,
    input  ts_t  acc_i,
    input  ts_t  cap_i,
    input  logic tail_vld_i,
    input  ts_t  tail_rel_i,
    output ts_t  rel_o,
    output logic over_o
);
    ts_t             last_res;
    logic [TS_W:0]   total;
    ts_t             comp;
    ts_t             own_rel;

    always_comb begin
        last_res = now_i - ingress_i;
        total    = {1'b0, acc_i} + {1'b0, last_res};
        if (total > {1'b0, cap_i}) begin
            over_o = 1'b1;
            comp   = '0;
        end else begin
            over_o = 1'b0;
            comp   = cap_i - total[TS_W-1:0];
        end
        own_rel = now_i + comp;
        // never overtake the entry queued last
        if (tail_vld_i && ts_after(tail_rel_i, own_rel)) rel_o = tail_rel_i;
        else                                             rel_o = own_rel;
    end
endmodule

// File: rtl/edc_release_queue.sv
module edc_release_queue
    import edc_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned DW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ts_t           now_i,
    input  logic          push_i,
    input  ts_t           push_rel_i,
    input  logic [DW-1:0] push_dat_i,
    input  logic          pop_i,
    output logic          full_o,
    output logic          tail_vld_o,
    output ts_t           tail_rel_o,
    output logic          due_o,
    output logic [DW-1:0] head_dat_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][TS_W-1:0] rel;
        logic [DEPTH-1:0][DW-1:0]   dat;
        logic [PTR_W-1:0]           rd;
        logic [PTR_W-1:0]           wr;
        logic [CNT_W-1:0]           cnt;
    } q_t;

    q_t st_d, st_q;

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    logic [PTR_W-1:0] tail_idx;
    logic [PTR_W-1:0] sec_idx;

    always_comb begin
        tail_idx = (st_q.wr == '0) ? LAST : st_q.wr - 1'b1;
        sec_idx  = nxt(st_q.rd);
    end

    always_comb begin
        st_d = st_q;
        if (pop_i) st_d.rd = nxt(st_q.rd);
        if (push_i) begin
            st_d.rel[st_q.wr] = push_rel_i;
            st_d.dat[st_q.wr] = push_dat_i;
            st_d.wr           = nxt(st_q.wr);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o     = (st_q.cnt == CNT_W'(DEPTH));
    assign tail_vld_o = (st_q.cnt != '0);
    assign tail_rel_o = st_q.rel[tail_idx];
    assign due_o      = (st_q.cnt != '0) && ts_reached(now_i, st_q.rel[st_q.rd]);
    assign head_dat_o = st_q.dat[st_q.rd];

    p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> st_q.cnt < CNT_W'(DEPTH));
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= CNT_W'(2)) |-> !ts_after(st_q.rel[st_q.rd], st_q.rel[sec_idx]));
endmodule

// File: rtl/edc_sched.sv
module edc_sched
    import edc_pkg::*;
#(
    parameter int unsigned FLOW_W    = 2,
    parameter int unsigned PATH_W    = 1,
    parameter int unsigned TAG_W     = 8,
    parameter int unsigned DEPTH     = 4,
    parameter logic [31:0] TIME_INIT = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FLOW_W-1:0] cfg_flow,
    input  logic [PATH_W-1:0] cfg_path,
    input  logic [31:0]       cfg_cap,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLOW_W-1:0] in_flow,
    input  logic [PATH_W-1:0] in_path,
    input  logic [31:0]       in_acc_res,
    input  logic [31:0]       in_ingress_ts,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FLOW_W-1:0] out_flow,
    output logic [PATH_W-1:0] out_path,
    output logic [TAG_W-1:0]  out_tag,
    output logic              over_budget,
    output logic [31:0]       now
);
    localparam int unsigned ADDR_W = FLOW_W + PATH_W;
    localparam int unsigned DW     = FLOW_W + PATH_W + TAG_W;

    typedef struct packed {
        ts_t  now;
        logic over;
    } top_t;

    top_t st_d, st_q;

    ts_t           cap_rd;
    ts_t           rel_w;
    logic          over_w;
    logic          full_w;
    logic          tail_vld_w;
    ts_t           tail_rel_w;
    logic          due_w;
    logic [DW-1:0] head_w;
    logic          accept;
    logic          pop;

    assign in_ready = !full_w;
    assign accept   = in_valid && !full_w;
    assign pop      = due_w && out_ready;

    edc_cap_table #(.ADDR_W(ADDR_W)) u_caps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr ({cfg_flow, cfg_path}),
        .wr_data (cfg_cap),
        .rd_addr ({in_flow, in_path}),
        .rd_data (cap_rd)
    );

    edc_budget u_budget (
        .now_i      (st_q.now),
        .ingress_i  (in_ingress_ts),
        .acc_i      (in_acc_res),
        .cap_i      (cap_rd),
        .tail_vld_i (tail_vld_w),
        .tail_rel_i (tail_rel_w),
        .rel_o      (rel_w),
        .over_o     (over_w)
    );

    edc_release_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .now_i      (st_q.now),
        .push_i     (accept),
        .push_rel_i (rel_w),
        .push_dat_i ({in_flow, in_path, in_tag}),
        .pop_i      (pop),
        .full_o     (full_w),
        .tail_vld_o (tail_vld_w),
        .tail_rel_o (tail_rel_w),
        .due_o      (due_w),
        .head_dat_o (head_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.now  = st_q.now + 1'b1;
        st_d.over = st_q.over | (accept & over_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.now  <= TIME_INIT;
            st_q.over <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign now         = st_q.now;
    assign over_budget = st_q.over;
    assign out_valid   = due_w;
    assign out_flow    = head_w[DW-1 -: FLOW_W];
    assign out_path    = head_w[TAG_W +: PATH_W];
    assign out_tag     = head_w[TAG_W-1:0];

    p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.now == $past(st_q.now) + 1'b1);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.over |=> st_q.over);
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable({out_flow, out_path, out_tag}));
endmodule

// File: tb/test_edc_sched.sv
module test_edc_sched;
    import edc_pkg::*;

    localparam int unsigned FLOW_W = 2;
    localparam int unsigned PATH_W = 1;
    localparam int unsigned TAG_W  = 8;
    localparam int unsigned DEPTH  = 4;
    localparam int unsigned NIDX   = 1 << (FLOW_W + PATH_W);
    localparam ts_t         T0     = 32'hFFFF_FF00;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [FLOW_W-1:0] cfg_flow = '0;
    logic [PATH_W-1:0] cfg_path = '0;
    logic [31:0]       cfg_cap = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [FLOW_W-1:0] in_flow = '0;
    logic [PATH_W-1:0] in_path = '0;
    logic [31:0]       in_acc_res = '0;
    logic [31:0]       in_ingress_ts = '0;
    logic [TAG_W-1:0]  in_tag = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [FLOW_W-1:0] out_flow;
    logic [PATH_W-1:0] out_path;
    logic [TAG_W-1:0]  out_tag;
    logic              over_budget;
    logic [31:0]       now;

    edc_sched #(.FLOW_W(FLOW_W), .PATH_W(PATH_W), .TAG_W(TAG_W),
                .DEPTH(DEPTH), .TIME_INIT(T0)) i_edc_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flow(cfg_flow),
        .cfg_path(cfg_path), .cfg_cap(cfg_cap), .in_valid(in_valid),
        .in_ready(in_ready), .in_flow(in_flow), .in_path(in_path),
        .in_acc_res(in_acc_res), .in_ingress_ts(in_ingress_ts), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready), .out_flow(out_flow),
        .out_path(out_path), .out_tag(out_tag), .over_budget(over_budget),
        .now(now)
    );

    always #10 clk = ~clk;

    int   n_tests = 0;
    int   n_fail  = 0;
    ts_t  cap_m [NIDX];
    logic over_m = 1'b0;
    ts_t  prev_rel = '0;
    ts_t  prev_emit = '0;
    bit   prev_vld = 1'b0;
    logic [TAG_W-1:0] sb_tag [64];
    ts_t  sb_time [64];
    bit   sb_tchk [64];
    int   sb_wr = 0;
    int   sb_rd = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void predict(int idx, ts_t acc, ts_t r, ts_t acc_now,
                                    logic [TAG_W-1:0] tag, bit timed);
        logic [32:0] tot;
        ts_t comp, own, rel, emit;
        tot = {1'b0, acc} + {1'b0, r};
        if (tot > {1'b0, cap_m[idx]}) begin
            over_m = 1'b1;
            comp   = '0;
        end else begin
            comp = cap_m[idx] - tot[31:0];
        end
        own = acc_now + comp;
        rel = own;
        if (prev_vld && !ts_after(acc_now, prev_emit) && ts_after(prev_rel, own))
            rel = prev_rel;
        emit = rel;
        if (ts_after(acc_now + 1, emit)) emit = acc_now + 1;
        if (prev_vld && ts_after(prev_emit + 1, emit)) emit = prev_emit + 1;
        prev_rel  = rel;
        prev_emit = emit;
        prev_vld  = timed;
        sb_tag[sb_wr % 64]  = tag;
        sb_time[sb_wr % 64] = emit;
        sb_tchk[sb_wr % 64] = timed;
        sb_wr++;
    endfunction

    task automatic send(input int idx, input ts_t acc, input ts_t r,
                        input logic [TAG_W-1:0] tag, input bit timed,
                        input bit do_cfg, input ts_t new_cap);
        @(negedge clk);
        in_flow       = FLOW_W'(idx >> PATH_W);
        in_path       = PATH_W'(idx);
        in_acc_res    = acc;
        in_ingress_ts = now - r;
        in_tag        = tag;
        in_valid      = 1'b1;
        if (do_cfg) begin
            cfg_we   = 1'b1;
            cfg_flow = FLOW_W'(idx >> PATH_W);
            cfg_path = PATH_W'(idx);
            cfg_cap  = new_cap;
        end
        predict(idx, acc, r, now, tag, timed);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        cfg_we   = 1'b0;
        if (do_cfg) cap_m[idx] = new_cap;
    endtask

    task automatic drain();
        int n = 0;
        while (sb_rd != sb_wr && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(sb_rd == sb_wr, "R3", "descriptors not all emitted", 64'(sb_wr - sb_rd), 0);
        @(negedge clk);
        prev_vld = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb_rd == sb_wr) begin
                chk(1'b0, "R7", "unexpected output tag", 64'(out_tag), 0);
            end else begin
                chk(out_tag == sb_tag[sb_rd % 64], "R6", "release order tag",
                    64'(out_tag), 64'(sb_tag[sb_rd % 64]));
                if (sb_tchk[sb_rd % 64])
                    chk(now == sb_time[sb_rd % 64], "R3", "release cycle",
                        64'(now), 64'(sb_time[sb_rd % 64]));
                sb_rd++;
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        ts_t a;
        int n;
        logic [TAG_W-1:0] t0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!out_valid, "R1", "out_valid in reset", 64'(out_valid), 0);
        chk(!over_budget, "R1", "over_budget in reset", 64'(over_budget), 0);
        chk(in_ready, "R1", "in_ready in reset", 64'(in_ready), 1);
        chk(now == T0, "R1", "now in reset", 64'(now), 64'(T0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(now == T0 + 1, "R1", "now after reset", 64'(now), 64'(T0 + 1));
        a = now;
        @(negedge clk);
        chk(now == a + 1, "R2", "counter step", 64'(now), 64'(a + 1));

        // program capacities, distinct per flow and path (R4)
        for (int i = 0; i < NIDX; i++) begin
            @(negedge clk);
            cfg_we   = 1'b1;
            cfg_flow = FLOW_W'(i >> PATH_W);
            cfg_path = PATH_W'(i);
            cfg_cap  = 32'(20 + 7 * i);
            @(posedge clk);
            #1;
            cfg_we   = 1'b0;
            cap_m[i] = 32'(20 + 7 * i);
        end

        // R10 release across the counter wrap, R2 wrap step
        n = 0;
        while (now != 32'hFFFF_FFF0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        send(5, 32'd2, 32'd3, 8'hA0, 1'b1, 1'b0, '0);
        n = 0;
        while (now != 32'hFFFF_FFFF && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        chk(now == 32'h0, "R2", "counter wrap", 64'(now), 0);
        drain();

        // R3 and R4: under budget and exactly on budget for every pair
        for (int i = 0; i < NIDX; i++) begin
            for (int c = 0; c < 2; c++) begin
                ts_t r;
                r = 32'(1 + i);
                if (c == 0) send(i, cap_m[i] - r - 32'(5 + i), r, 8'(3 * i + c), 1'b1, 1'b0, '0);
                else        send(i, cap_m[i] - r, r, 8'(3 * i + c), 1'b1, 1'b0, '0);
                drain();
            end
        end
        chk(over_budget == 1'b0, "R5", "flag after equal totals", 64'(over_budget), 0);

        // R5 over budget: release at once, sticky flag
        for (int i = 0; i < NIDX; i++) begin
            ts_t r;
            r = 32'(2 + i);
            send(i, cap_m[i] - r + 32'd4, r, 8'(3 * i + 2), 1'b1, 1'b0, '0);
            drain();
            chk(over_budget == over_m, "R5", "sticky over flag", 64'(over_budget), 64'(over_m));
        end

        // R9 write at the same edge as a lookup uses the old value
        send(1, 32'd0, 32'd0, 8'h90, 1'b1, 1'b1, 32'd10);
        drain();
        send(1, 32'd0, 32'd0, 8'h91, 1'b1, 1'b0, '0);
        drain();

        // R6 later packets with earlier own release keep order
        send(7, 32'd0, 32'd0, 8'h60, 1'b1, 1'b0, '0);
        send(0, 32'd0, 32'd0, 8'h61, 1'b1, 1'b0, '0);
        send(1, 32'd0, 32'd0, 8'h62, 1'b1, 1'b0, '0);
        send(2, 32'd30, 32'd1, 8'h63, 1'b1, 1'b0, '0);
        drain();

        // R8 output holds while stalled
        out_ready = 1'b0;
        send(0, 32'd20, 32'd0, 8'h80, 1'b0, 1'b0, '0);
        n = 0;
        while (!out_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        t0 = out_tag;
        chk(t0 == 8'h80, "R8", "stalled head tag", 64'(t0), 64'h80);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(out_valid && out_tag == t0, "R8", "hold under stall",
                64'({out_valid, out_tag}), 64'({1'b1, t0}));
        end
        out_ready = 1'b1;
        drain();

        // R7 full queue stalls input, offered descriptor ignored
        out_ready = 1'b0;
        for (int k = 0; k < DEPTH; k++)
            send(2, 32'd0, 32'd0, 8'(8'h70 + k), 1'b0, 1'b0, '0);
        @(negedge clk);
        chk(!in_ready, "R7", "in_ready when full", 64'(in_ready), 0);
        in_tag   = 8'hEE;
        in_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!in_ready, "R7", "in_ready stays low", 64'(in_ready), 0);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        drain();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!out_valid, "R7", "no extra descriptor", 64'(out_valid), 0);
        end

        summary();
        $finish;
    end
endmodule